// File: doc/BRIEF.md
# SD Command Line Engine

This block runs the command half of an SD card bus in one-bit mode. It generates the card clock and drives the bidirectional command line. It also listens on that line for the card's answer. The host presents a 6-bit command index and a 32-bit argument, then pulses `start`. The engine builds a 48-bit frame with a CRC7 checksum computed up front. It shifts the frame out most significant bit first, changing the line on each falling clock edge.

Once the end bit has gone out, the engine releases the line and keeps the clock running. It watches on rising edges for the card's low start bit, which may arrive after any number of clocks. It then captures either a 48-bit or a 136-bit response into a shift register wide enough for the long form. If the card stays silent for a programmed number of clocks, the engine stops with a timeout flag. The clock always rests high between commands, so a pull-up can hold it when the pin is released.

Top module: `sd_cmd_engine`

## Requirements
- R1: Each command goes out as 48 bits, first to last: a 0 start bit, a 1 direction bit, the index (bit 5 first), the argument (bit 31 first), the CRC7 (bit 6 first) and a closing 1. Every new command reloads the whole frame, so nothing left over from an earlier transfer precedes its start bit.
- R2: The CRC7 uses polynomial x^7 + x^3 + 1 with a zero initial value, taken over the first 40 frame bits.
- R3: `sdClk` is high out of reset, before the first falling edge of a command and after `done`. `cmdOe` stays low until the first falling edge, and `cmdOut` changes only together with a falling edge of `sdClk`.
- R4: `cmdOe` drops on the falling edge that follows the end bit, and it stays low through the hunt and the capture.
- R5: The engine samples `cmdIn` on rising edges of `sdClk`. The first sampled 0 begins the response, however many idle high samples come before it.
- R6: With `longResp` = 0, exactly 48 bits are captured. The first received bit ends in `resp[47]`, the last in `resp[0]`, and bits above 47 read 0.
- R7: With `longResp` = 1, exactly 136 bits are captured, the first received bit in `resp[135]`.
- R8: If `tmoLimit` rising edges in a row sample `cmdIn` high after release, the engine finishes with `timedOut` = 1 and `resp` = 0, leaving `sdClk` high. `timedOut` holds until the next command starts.
- R9: Each half period of `sdClk` lasts `clkDiv` + 1 system clock cycles.
- R10: A `start` pulse while `busy` is high is ignored: the frame in flight is not changed and no further command follows.
- R11: `busy` rises in the cycle after an accepted `start`. `done` is a one-cycle pulse, and `busy` falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command when idle |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| longResp | input | 1 | 1 selects a 136-bit response, 0 a 48-bit one |
| clkDiv | input | DIV_W | Half-period of sdClk minus one, in system cycles |
| tmoLimit | input | TMO_W | Rising edges to wait for a start bit (at least 1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Last command saw no response |
| resp | output | 136 | Captured response, right-aligned |
| sdClk | output | 1 | Card clock, idles high |
| cmdOut | output | 1 | Command line output value |
| cmdOe | output | 1 | Command line output enable |
| cmdIn | input | 1 | Command line input (pulled high) |

## Verification
The bench builds the engine with a 4-bit divider and a 10-bit timeout counter. This lets it step the clock through divider values 0 to 3 and measure half periods as short as one system cycle. It also lets it wait out a 20-clock timeout within a few hundred cycles. Frames are checked against well-known CRC7 values for several index/argument pairs. A card model answers with zero to five idle clocks before both response lengths. It also pulses `start` in the middle of a transfer.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_W    = 48;
  localparam int HEAD_W     = 40;
  localparam int RESP_SHORT = 48;
  localparam int RESP_LONG  = 136;
  localparam int CNT_W      = $clog2(RESP_LONG + 1);
  localparam logic [6:0] CRC_TAPS = 7'h09;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TX,
    PH_HUNT,
    PH_RX,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadFrame;
    logic clkRun;
    logic shiftTx;
    logic releaseLine;
    logic captureBit;
  } strobe_t;

  // serial-equivalent CRC7 over the header, evaluated in one cycle
  function automatic logic [6:0] crc7Of(input logic [HEAD_W-1:0] head);
    logic [6:0] acc;
    logic fb;
    acc = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) begin
      fb  = head[i] ^ acc[6];
      acc = {acc[5:0], 1'b0};
      if (fb) acc = acc ^ CRC_TAPS;
    end
    return acc;
  endfunction

endpackage

// File: rtl/sd_cmd_dpath.sv
module sd_cmd_dpath
  import sd_cmd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int RESP_W = RESP_LONG
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [5:0]        cmdIndex,
  input  logic [31:0]       cmdArg,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              cmdIn,
  output logic              fallEv,
  output logic              riseEv,
  output logic              sdClk,
  output logic              cmdOut,
  output logic              cmdOe,
  output logic [RESP_W-1:0] resp
);

  logic [DIV_W-1:0]   divCnt;
  logic               tick;
  logic [FRAME_W-1:0] txShift;
  logic [HEAD_W-1:0]  head;
  logic [FRAME_W-1:0] frame;

  assign head  = {2'b01, cmdIndex, cmdArg};
  assign frame = {head, crc7Of(head), 1'b1};

  // clock divider: one tick per half period
  assign tick   = strb.clkRun && (divCnt == clkDiv);
  assign fallEv = tick && sdClk;
  assign riseEv = tick && !sdClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sdClk  <= 1'b1;
    end else if (!strb.clkRun) begin
      divCnt <= '0;
      sdClk  <= 1'b1;
    end else if (tick) begin
      divCnt <= '0;
      sdClk  <= !sdClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // transmit shifter, launched on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      cmdOut  <= 1'b1;
      cmdOe   <= 1'b0;
    end else begin
      if (strb.loadFrame) begin
        txShift <= frame;
        cmdOe   <= 1'b0;
        cmdOut  <= 1'b1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
        cmdOut  <= txShift[FRAME_W-1];
        cmdOe   <= 1'b1;
      end else if (strb.releaseLine) begin
        cmdOe   <= 1'b0;
        cmdOut  <= 1'b1;
      end
    end
  end

  // receive shifter, sampled on rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resp <= '0;
    end else if (strb.loadFrame) begin
      resp <= '0;
    end else if (strb.captureBit) begin
      resp <= {resp[RESP_W-2:0], cmdIn};
    end
  end

  // R3: the line value moves only together with a falling clock edge
  p_launch_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdOe) && cmdOe && (cmdOut != $past(cmdOut))) |-> ($past(sdClk) && !sdClk));

  // R5: captures happen only in the cycle a rising edge is produced
  p_capture_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureBit |=> sdClk);

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             longResp,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             fallEv,
  input  logic             riseEv,
  input  logic             cmdIn,
  input  logic             sdClk,
  input  logic             cmdOe,
  output strobe_t          strb,
  output logic             busy,
  output logic             done,
  output logic             timedOut
);

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic             lenLong;
  logic [CNT_W-1:0] respLen;

  assign respLen = lenLong ? CNT_W'(RESP_LONG) : CNT_W'(RESP_SHORT);

  always_comb begin
    strb.loadFrame   = (phase == PH_IDLE) && start;
    strb.clkRun      = (phase == PH_TX) || (phase == PH_HUNT) || (phase == PH_RX);
    strb.shiftTx     = (phase == PH_TX) && fallEv && (bitCnt != CNT_W'(FRAME_W));
    strb.releaseLine = (phase == PH_TX) && fallEv && (bitCnt == CNT_W'(FRAME_W));
    strb.captureBit  = riseEv && (((phase == PH_HUNT) && !cmdIn) || (phase == PH_RX));
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      tmoCnt   <= '0;
      lenLong  <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_TX;
          bitCnt   <= '0;
          tmoCnt   <= '0;
          lenLong  <= longResp;
          timedOut <= 1'b0;
        end
        PH_TX: if (fallEv) begin
          if (bitCnt == CNT_W'(FRAME_W)) begin
            phase  <= PH_HUNT;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_HUNT: if (riseEv) begin
          if (!cmdIn) begin
            phase  <= PH_RX;
            bitCnt <= CNT_W'(1);
          end else if (tmoCnt == tmoLimit - 1'b1) begin
            phase    <= PH_DONE;
            timedOut <= 1'b1;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        PH_RX: if (riseEv) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt + 1'b1 == respLen) phase <= PH_DONE;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: clock rests high whenever no command is running
  p_idle_clk_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> sdClk);

  // R4: line stays released while listening
  p_line_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_HUNT) || (phase == PH_RX)) |-> !cmdOe);

  // R11: completion is a single-cycle pulse followed by idle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R10: a start during a transfer does not cut it short
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

  // R6 / R7: successful completion has counted exactly the selected length
  p_rx_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timedOut) |-> (bitCnt == respLen));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [5:0]           cmdIndex,
  input  logic [31:0]          cmdArg,
  input  logic                 longResp,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic [TMO_W-1:0]     tmoLimit,
  output logic                 busy,
  output logic                 done,
  output logic                 timedOut,
  output logic [RESP_LONG-1:0] resp,
  output logic                 sdClk,
  output logic                 cmdOut,
  output logic                 cmdOe,
  input  logic                 cmdIn
);

  strobe_t strb;
  logic    fallEv;
  logic    riseEv;

  sd_cmd_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .longResp (longResp),
    .tmoLimit (tmoLimit),
    .fallEv   (fallEv),
    .riseEv   (riseEv),
    .cmdIn    (cmdIn),
    .sdClk    (sdClk),
    .cmdOe    (cmdOe),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .timedOut (timedOut)
  );

  sd_cmd_dpath #(.DIV_W(DIV_W), .RESP_W(RESP_LONG)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdIndex (cmdIndex),
    .cmdArg   (cmdArg),
    .clkDiv   (clkDiv),
    .cmdIn    (cmdIn),
    .fallEv   (fallEv),
    .riseEv   (riseEv),
    .sdClk    (sdClk),
    .cmdOut   (cmdOut),
    .cmdOe    (cmdOe),
    .resp     (resp)
  );

endmodule

// File: tb/sd_cmd_engine_bench.sv
`timescale 1ns/1ps
module sd_cmd_engine_bench;

  localparam int DIV_W = 4;
  localparam int TMO_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0] cmdIndex = '0;
  logic [31:0] cmdArg = '0;
  logic longResp = 1'b0;
  logic [DIV_W-1:0] clkDiv = '0;
  logic [TMO_W-1:0] tmoLimit = 10'd64;
  logic busy, done, timedOut, sdClk, cmdOut, cmdOe;
  logic [135:0] resp;
  logic cmdIn = 1'b1;

  int nChecks = 0;
  int nFail = 0;
  int rises = 0;
  int monCnt = 0;
  logic [47:0] monSh = '0;
  logic [47:0] expQ[$];

  always #2.5 clk = !clk;

  sd_cmd_engine #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_sd_cmd_engine (
    .clk(clk), .rstN(rstN), .start(start), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .longResp(longResp), .clkDiv(clkDiv), .tmoLimit(tmoLimit), .busy(busy),
    .done(done), .timedOut(timedOut), .resp(resp), .sdClk(sdClk),
    .cmdOut(cmdOut), .cmdOe(cmdOe), .cmdIn(cmdIn)
  );

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: collect driven bits at rising clock edges, compare against scoreboard
  always @(posedge sdClk) begin
    if (busy && !cmdOe) rises++;
    if (cmdOe) begin
      monSh = {monSh[46:0], cmdOut};
      monCnt++;
      if (monCnt == 48) begin
        monCnt = 0;
        if (expQ.size() == 0) chk(1'b0, "R1 unexpected frame", 136'(monSh), '0);
        else begin
          logic [47:0] e;
          e = expQ.pop_front();
          chk(monSh == e, "R1 R2 frame", 136'(monSh), 136'(e));
        end
      end
    end
  end

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [6:0] crc,
                       input logic lr, input int div, input int tmo, input bit respond,
                       input int dly, input logic [135:0] rv, input bit poke);
    int len;
    logic [135:0] expResp;
    int expRises;
    len = lr ? 136 : 48;
    expResp = !respond ? '0 : (lr ? rv : {88'b0, rv[47:0]});
    expRises = respond ? (dly + 1 + len) : tmo;
    expQ.push_back({2'b01, idx, arg, crc, 1'b1});
    @(negedge clk);
    cmdIndex = idx; cmdArg = arg; longResp = lr;
    clkDiv = DIV_W'(div); tmoLimit = TMO_W'(tmo);
    rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", 136'(busy), 136'(1));
    chk(sdClk == 1'b1 && cmdOe == 1'b0, "R3 clock high and line released before first fall",
        136'({sdClk, cmdOe}), 136'(2'b10));
    fork
      begin : card
        if (respond) begin
          @(negedge cmdOe);
          #1;
          repeat (dly) @(negedge sdClk);
          for (int i = len - 1; i >= 0; i--) begin
            @(negedge sdClk);
            #1 cmdIn = rv[i];
          end
          wait (done);
          @(negedge clk);
          cmdIn = 1'b1;
        end
      end
      begin : measure
        realtime t0, t1;
        @(negedge sdClk); t0 = $realtime;
        @(posedge sdClk); t1 = $realtime;
        chk((t1 - t0) > (div + 1) * 5.0 - 0.1 && (t1 - t0) < (div + 1) * 5.0 + 0.1,
            "R9 half period", 136'($rtoi(t1 - t0)), 136'((div + 1) * 5));
      end
      begin : pokeStart
        if (poke) begin
          repeat (30) @(negedge clk);
          start = 1'b1; cmdIndex = 6'h2A;
          @(negedge clk);
          start = 1'b0; cmdIndex = idx;
        end
      end
      begin : finish
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(timedOut == !respond, "R8 timeout flag", 136'(timedOut), 136'(!respond));
        chk(resp == expResp, lr ? "R7 long response" : "R6 short response", resp, expResp);
        chk(rises == expRises, "R5 clocks until done", 136'(rises), 136'(expRises));
        chk(cmdOe == 1'b0, "R4 line released at done", 136'(cmdOe), 136'(0));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11 done pulse width", 136'({done, busy}), 136'(0));
        chk(sdClk == 1'b1, "R3 clock high after done", 136'(sdClk), 136'(1));
        chk(timedOut == !respond, "R8 flag held", 136'(timedOut), 136'(!respond));
      end
    join
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdClk == 1'b1 && cmdOe == 1'b0 && busy == 1'b0 && done == 1'b0, "R3 reset state",
        136'({sdClk, cmdOe, busy, done}), 136'(4'b1000));
    rstN = 1'b1;
    @(negedge clk);
    chk(resp == '0, "R6 reset response", resp, '0);
    // index 0, arg 0 -> CRC 0x4A
    issue(6'd0, 32'h0, 7'h4A, 1'b0, 3, 64, 1'b1, 0, 136'h01_2345_6789_AB, 1'b0);
    // index 8, arg 0x1AA -> CRC 0x43, card waits 5 clocks
    issue(6'd8, 32'h0000_01AA, 7'h43, 1'b0, 1, 64, 1'b1, 5, 136'h08_0000_01AA_13, 1'b0);
    // index 17, arg 0 -> CRC 0x2A, long answer
    issue(6'd17, 32'h0, 7'h2A, 1'b1, 0, 64, 1'b1, 2,
          {8'h3F, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 1'b0);
    // index 55, arg 0 -> CRC 0x32, silent card
    issue(6'd55, 32'h0, 7'h32, 1'b0, 2, 20, 1'b0, 0, '0, 1'b0);
    // after a long answer and a timeout, a new frame starts cleanly; start pulsed mid-transfer
    issue(6'd0, 32'h0, 7'h4A, 1'b0, 0, 64, 1'b1, 1, 136'h3F_FFFF_0000_01, 1'b1);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0, "R10 no command from ignored start", 136'(busy), 136'(0));
    chk(expQ.size() == 0 && monCnt == 0, "R10 R1 frame count", 136'(expQ.size() + monCnt), 136'(0));
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule